// File: doc/BRIEF.md
# Page Write Cache with Wrapping Pointer

This block sits between a serial slave engine and the programmer of a nonvolatile array. It collects the data bytes of one write transfer in a 64-byte cache, organised as eight lines of eight bytes. Nothing reaches the array until the transfer is closed with a stop. At the start of a transfer the engine strobes in a 13-bit start address. The seven upper bits of that address are frozen as the page base. The six lower bits form a byte pointer, and this pointer steps by one with every received data byte.

The pointer wraps from offset 63 back to offset 0. Moving from the last byte of one line continues into the first byte of the next line. A transfer longer than the cache therefore overwrites bytes captured earlier. A per-byte valid mask records which cache bytes hold data. On stop, the block sends the array programmer one address/data pair per valid byte, in ascending offset order, and then pulses done. An abort throws the cache contents away without committing anything.

Top module: `page_cache`

## Requirements
- R1: While reset is asserted, and right after it is released, cmt_valid_o and cmt_done_o are low and cmt_addr_o and cmt_data_o are zero.
- R2: load_i takes addr_i. The first data byte after it is stored at cache offset addr_i[5:0]. Every committed address carries addr_i[12:6] as its bits [12:6].
- R3: Each data byte accepted while capturing advances the 6-bit offset by one, wrapping from 63 to 0. Bits [12:6] of the committed addresses stay equal to the loaded base, even across that wrap.
- R4: Stepping from offset 7 of a line (offset bits [2:0] = 7) continues at offset 0 of the next line, so a run of bytes is stored contiguously across line boundaries.
- R5: When more bytes arrive than the cache holds, a byte stored at an already written offset replaces the earlier one. Only the latest value is committed, and it is committed once.
- R6: cmt_valid_o and cmt_done_o stay low from load_i until the cycle after stop_i.
- R7: From the second rising edge after stop_i is sampled, the block emits one pair per cycle with no gaps, one for each written offset in ascending offset order. Each pair carries address {base, offset} and the stored byte.
- R8: cmt_done_o pulses for exactly one cycle, in the cycle right after the last pair. If no byte was written, it pulses in the cycle in which the first pair would have appeared.
- R9: abort_i discards the captured bytes. No pair and no done follow, and a later stop_i without a new load_i produces nothing.
- R10: byte_i and stop_i while idle (no load since the last commit or abort), and load_i, byte_i and stop_i while commit pairs are being emitted, have no effect.
- R11: load_i during capture starts a new transfer. Bytes captured before it are discarded. When inputs coincide, abort_i wins over load_i, which wins over stop_i, which wins over byte_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Start-of-transfer strobe, takes addr_i |
| addr_i | input | 13 | Start address of the transfer |
| byte_i | input | 1 | Data byte strobe |
| data_i | input | 8 | Data byte |
| stop_i | input | 1 | Close the transfer and commit |
| abort_i | input | 1 | Discard the transfer |
| cmt_valid_o | output | 1 | One commit pair is valid this cycle |
| cmt_addr_o | output | 13 | Array address of the commit pair |
| cmt_data_o | output | 8 | Data of the commit pair |
| cmt_done_o | output | 1 | Commit finished (one-cycle pulse) |

## Verification
Any internal fault becomes visible only at commit. If the offset is stepped wrongly or the base is corrupted, the commit addresses shift. If the mask is wrong, pairs go missing, appear twice or carry stale data. A fault in the drain selector breaks the ascending order or leaves gaps in the pair stream. The bench compares every pair against a model of the pointer and mask. Pairs are checked in the exact cycle each must appear, starting two edges after stop. This way a one-cycle timing slip is caught in the same commit that contains it.

// File: rtl/page_cache_pkg.sv
package page_cache_pkg;
  typedef enum logic [1:0] {
    PC_IDLE  = 2'd0,
    PC_CAPT  = 2'd1,
    PC_DRAIN = 2'd2
  } pc_state_e;
endpackage

// File: rtl/page_cache_ptr.sv
// Frozen page base plus wrapping byte offset.
module page_cache_ptr #(
  parameter int ADDR_W = 13,
  parameter int OFF_W  = 6,
  localparam int BASE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              step_i,
  output logic [BASE_W-1:0] base_o,
  output logic [OFF_W-1:0]  off_o
);
  logic [BASE_W-1:0] base_q, base_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic              upd_en;

  always_comb begin
    base_d = base_q;
    off_d  = off_q;
    upd_en = load_i | step_i;
    if (load_i) begin
      base_d = addr_i[ADDR_W-1:OFF_W];
      off_d  = addr_i[OFF_W-1:0];
    end else if (step_i) begin
      off_d = off_q + OFF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
    end else if (upd_en) begin
      base_q <= base_d;
      off_q  <= off_d;
    end
  end

  assign base_o = base_q;
  assign off_o  = off_q;

  // R3
  off_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (off_o == OFF_W'($past(off_o) + 1'b1)));
  // R3
  base_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> $stable(base_o));
  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (off_o == $past(addr_i[OFF_W-1:0])));
endmodule

// File: rtl/page_cache_store.sv
// Byte storage in lines plus the per-byte valid mask.
module page_cache_store #(
  parameter int OFF_W  = 6,
  parameter int LINE_W = 3,
  parameter int DATA_W = 8,
  localparam int DEPTH  = 1 << OFF_W,
  localparam int LINE_B = 1 << LINE_W,
  localparam int LINES  = DEPTH / LINE_B,
  localparam int LSEL_W = OFF_W - LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_all_i,
  input  logic              clr_i,
  input  logic [OFF_W-1:0]  clr_idx_i,
  input  logic [OFF_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DEPTH-1:0]  mask_o
);
  logic [LINE_B*DATA_W-1:0] line_flat [LINES];
  logic [DEPTH-1:0] mask_q, mask_d, set_vec, clr_vec;
  logic             mask_en;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [DATA_W-1:0] cell_q [LINE_B];
    logic              line_hit;
    assign line_hit = wr_i && (wr_idx_i[OFF_W-1:LINE_W] == LSEL_W'(l));
    always_ff @(posedge clk) begin
      if (line_hit) cell_q[wr_idx_i[LINE_W-1:0]] <= wr_data_i;
    end
    for (genvar b = 0; b < LINE_B; b++) begin : g_byte
      assign line_flat[l][b*DATA_W +: DATA_W] = cell_q[b];
    end
  end

  assign rd_data_o =
    line_flat[rd_idx_i[OFF_W-1:LINE_W]][rd_idx_i[LINE_W-1:0]*DATA_W +: DATA_W];

  always_comb begin
    set_vec = wr_i  ? (DEPTH'(1) << wr_idx_i)  : '0;
    clr_vec = clr_i ? (DEPTH'(1) << clr_idx_i) : '0;
    mask_en = clr_all_i | wr_i | clr_i;
    if (clr_all_i) mask_d = '0;
    else           mask_d = (mask_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // R5
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !clr_all_i) |=> mask_o[$past(wr_idx_i)]);
  // R9
  mask_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> (mask_o == '0));
endmodule

// File: rtl/page_cache_pick.sv
// Lowest set bit of the valid mask.
module page_cache_pick #(
  parameter int OFF_W = 6,
  localparam int DEPTH = 1 << OFF_W
) (
  input  logic [DEPTH-1:0] mask_i,
  output logic [OFF_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        idx_o = OFF_W'(i);
        any_o = 1'b1;
      end
    end
  end

  always_comb begin
    if (any_o) begin
      // R7
      pick_hit_chk: assert (mask_i[idx_o]);
      // R7
      pick_lowest_chk: assert ((mask_i & ((DEPTH'(1) << idx_o) - DEPTH'(1))) == '0);
    end
  end
endmodule

// File: rtl/page_cache.sv
module page_cache
  import page_cache_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 6,
  parameter int LINE_W = 3,
  localparam int BASE_W = ADDR_W - OFF_W,
  localparam int DEPTH  = 1 << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stop_i,
  input  logic              abort_i,
  output logic              cmt_valid_o,
  output logic [ADDR_W-1:0] cmt_addr_o,
  output logic [DATA_W-1:0] cmt_data_o,
  output logic              cmt_done_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pc_state_e         st_q, st_d;
  logic              ptr_load, ptr_step, st_wr, clr_all, clr_one;
  logic [BASE_W-1:0] base;
  logic [OFF_W-1:0]  off, pick_idx;
  logic              pick_any;
  logic [DATA_W-1:0] rd_data;
  logic [DEPTH-1:0]  mask;
  logic              valid_q, valid_d, done_q, done_d, pair_en;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;

  page_cache_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
    .clk(clk), .rst_n(rst_int_n), .load_i(ptr_load), .addr_i(addr_i),
    .step_i(ptr_step), .base_o(base), .off_o(off)
  );

  page_cache_store #(.OFF_W(OFF_W), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_int_n), .wr_i(st_wr), .wr_idx_i(off),
    .wr_data_i(data_i), .clr_all_i(clr_all), .clr_i(clr_one),
    .clr_idx_i(pick_idx), .rd_idx_i(pick_idx), .rd_data_o(rd_data),
    .mask_o(mask)
  );

  page_cache_pick #(.OFF_W(OFF_W)) u_pick (
    .mask_i(mask), .idx_o(pick_idx), .any_o(pick_any)
  );

  always_comb begin
    st_d     = st_q;
    ptr_load = 1'b0;
    ptr_step = 1'b0;
    st_wr    = 1'b0;
    clr_all  = 1'b0;
    clr_one  = 1'b0;
    valid_d  = 1'b0;
    done_d   = 1'b0;
    pair_en  = 1'b0;
    addr_d   = addr_q;
    data_d   = data_q;
    if (abort_i) begin
      st_d    = PC_IDLE;
      clr_all = 1'b1;
    end else begin
      unique case (st_q)
        PC_IDLE: begin
          if (load_i) begin
            st_d     = PC_CAPT;
            ptr_load = 1'b1;
            clr_all  = 1'b1;
          end
        end
        PC_CAPT: begin
          if (load_i) begin
            ptr_load = 1'b1;
            clr_all  = 1'b1;
          end else if (stop_i) begin
            st_d = PC_DRAIN;
          end else if (byte_i) begin
            st_wr    = 1'b1;
            ptr_step = 1'b1;
          end
        end
        PC_DRAIN: begin
          if (pick_any) begin
            valid_d = 1'b1;
            pair_en = 1'b1;
            clr_one = 1'b1;
            addr_d  = {base, pick_idx};
            data_d  = rd_data;
          end else begin
            done_d = 1'b1;
            st_d   = PC_IDLE;
          end
        end
        default: st_d = PC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q    <= PC_IDLE;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      valid_q <= valid_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (pair_en) begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign cmt_valid_o = valid_q;
  assign cmt_done_o  = done_q;
  assign cmt_addr_o  = addr_q;
  assign cmt_data_o  = data_q;

  // R8
  valid_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(cmt_valid_o && cmt_done_o));
  // R6
  valid_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmt_valid_o |-> ($past(st_q) == PC_DRAIN));
  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    abort_i |=> (!cmt_valid_o && !cmt_done_o));
  // R7
  ascending_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmt_valid_o && $past(cmt_valid_o)) |->
      (cmt_addr_o[OFF_W-1:0] > $past(cmt_addr_o[OFF_W-1:0])));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmt_done_o |-> (st_q == PC_IDLE));
endmodule

// File: tb/page_cache_bench.sv
module page_cache_bench;
  localparam int NV    = 7;
  localparam int DEPTH = 64;
  // {start address[28:16], byte count[15:8], first data value[7:0]}
  localparam logic [28:0] VEC [NV] = '{
    {13'h0000, 8'd1,  8'h11},  // single byte at offset 0
    {13'h1234, 8'd5,  8'h40},  // mid-page start
    {13'h0006, 8'd4,  8'h70},  // R4 crosses a line boundary
    {13'h1FFC, 8'd8,  8'hA0},  // R3 wraps offset 63 to 0
    {13'h0A40, 8'd64, 8'h01},  // full cache
    {13'h0005, 8'd70, 8'h80},  // R5 overwrite after wrap
    {13'h0100, 8'd0,  8'h00}   // R8 empty commit
  };

  logic        clk, rst_n, load_i, byte_i, stop_i, abort_i;
  logic [12:0] addr_i;
  logic [7:0]  data_i;
  logic        cmt_valid_o, cmt_done_o;
  logic [12:0] cmt_addr_o;
  logic [7:0]  cmt_data_o;

  page_cache u_page_cache (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .addr_i(addr_i),
    .byte_i(byte_i), .data_i(data_i), .stop_i(stop_i), .abort_i(abort_i),
    .cmt_valid_o(cmt_valid_o), .cmt_addr_o(cmt_addr_o),
    .cmt_data_o(cmt_data_o), .cmt_done_o(cmt_done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int   n_chk, n_bad, stray;
  bit   collecting, finished;
  logic [6:0] m_base;
  logic [5:0] m_off;
  logic       m_msk [DEPTH];
  logic [7:0] m_dat [DEPTH];

  always @(negedge clk)
    if (rst_n && !collecting && (cmt_valid_o || cmt_done_o)) stray++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic drive(input logic l, input logic [12:0] a, input logic b,
                       input logic [7:0] d, input logic s, input logic ab);
    @(negedge clk);
    load_i = l; addr_i = a; byte_i = b; data_i = d; stop_i = s; abort_i = ab;
  endtask

  task automatic idle();
    drive(1'b0, 13'h0, 1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) m_msk[i] = 1'b0;
  endtask

  task automatic send_load(input logic [12:0] a);
    drive(1'b1, a, 1'b0, 8'h00, 1'b0, 1'b0);
    m_base = a[12:6];
    m_off  = a[5:0];
    model_clear();
  endtask

  task automatic send_byte(input logic [7:0] d);
    drive(1'b0, 13'h0, 1'b1, d, 1'b0, 1'b0);
    m_dat[m_off] = d;
    m_msk[m_off] = 1'b1;
    m_off = m_off + 6'd1;
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!cmt_valid_o && !cmt_done_o, tag, {cmt_valid_o, cmt_done_o}, 0);
    end
  endtask

  task automatic do_commit(input bit disturb);
    int cnt;
    int s;
    cnt = 0;
    s = 0;
    for (int i = 0; i < DEPTH; i++) if (m_msk[i]) cnt++;
    collecting = 1'b1;
    drive(1'b0, 13'h0, 1'b0, 8'h00, 1'b1, 1'b0);
    idle();
    for (int j = 0; j <= cnt; j++) begin
      @(negedge clk);
      if (j < cnt) begin
        while (!m_msk[s]) s++;
        chk(cmt_valid_o, "R7 pair valid", cmt_valid_o, 1);
        chk(cmt_addr_o == {m_base, 6'(s)}, "R2 R3 commit address",
            cmt_addr_o, {m_base, 6'(s)});
        chk(cmt_data_o == m_dat[s], "R5 R7 commit data", cmt_data_o, m_dat[s]);
        s++;
      end else begin
        chk(cmt_done_o && !cmt_valid_o, "R8 done after last pair",
            {cmt_valid_o, cmt_done_o}, 1);
      end
      // R10 inputs during the pair stream must be ignored
      if (disturb && j < 2) begin
        load_i = 1'b1; addr_i = 13'h0000; byte_i = 1'b1; data_i = 8'hEE; stop_i = 1'b1;
      end else begin
        load_i = 1'b0; byte_i = 1'b0; stop_i = 1'b0;
      end
    end
    @(negedge clk);
    chk(!cmt_done_o && !cmt_valid_o, "R8 done single pulse",
        {cmt_valid_o, cmt_done_o}, 0);
    collecting = 1'b0;
    model_clear();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    n_chk = 0; n_bad = 0; stray = 0; collecting = 1'b0; finished = 1'b0;
    model_clear();
    rst_n = 1'b0;
    load_i = 1'b0; addr_i = '0; byte_i = 1'b0; data_i = '0; stop_i = 1'b0; abort_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!cmt_valid_o && !cmt_done_o, "R1 flags in reset", {cmt_valid_o, cmt_done_o}, 0);
    chk(cmt_addr_o == 0 && cmt_data_o == 0, "R1 pair in reset", {cmt_addr_o, cmt_data_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!cmt_valid_o && !cmt_done_o, "R1 flags after release", {cmt_valid_o, cmt_done_o}, 0);
    chk(cmt_addr_o == 0 && cmt_data_o == 0, "R1 pair after release",
        {cmt_addr_o, cmt_data_o}, 0);

    for (int v = 0; v < NV; v++) begin
      send_load(VEC[v][28:16]);
      for (int i = 0; i < int'(VEC[v][15:8]); i++) send_byte(VEC[v][7:0] + 8'(i));
      do_commit(1'b0);
      idle();
    end

    // R9 abort discards the capture
    send_load(13'h0800);
    for (int i = 0; i < 4; i++) send_byte(8'hC0 + 8'(i));
    drive(1'b0, 13'h0, 1'b0, 8'h00, 1'b0, 1'b1);
    idle();
    quiet(4, "R9 no output after abort");
    drive(1'b0, 13'h0, 1'b0, 8'h00, 1'b1, 1'b0);
    idle();
    quiet(4, "R9 stop after abort");
    model_clear();

    // R10 bytes and stop while idle
    for (int i = 0; i < 3; i++) drive(1'b0, 13'h0, 1'b1, 8'h55, 1'b0, 1'b0);
    drive(1'b0, 13'h0, 1'b0, 8'h00, 1'b1, 1'b0);
    idle();
    quiet(4, "R10 idle bytes ignored");

    // R10 inputs during the pair stream
    send_load(13'h0A13);
    for (int i = 0; i < 5; i++) send_byte(8'h30 + 8'(i));
    do_commit(1'b1);
    idle();
    quiet(4, "R10 no capture from drain-time inputs");

    // R11 reload during capture discards earlier bytes
    send_load(13'h0300);
    for (int i = 0; i < 3; i++) send_byte(8'hD0 + 8'(i));
    send_load(13'h1E3E);
    for (int i = 0; i < 4; i++) send_byte(8'h60 + 8'(i));
    do_commit(1'b0);
    idle();

    chk(stray == 0, "R6 no output outside commit", stray, 0);
    summary();
  end
endmodule